// File: doc/BRIEF.md
# Receive Character Queue with Automatic Request-to-Send

This block is the receive-side character store of a serial port. A bit-level receiver, not part of this block, signals each detected start bit. When a character finishes, the receiver pushes its data byte into the store together with three status bits: break, framing error and parity error. The host reads the oldest character from the top of the queue and removes it with a pop strobe. The queue holds eight characters by default.

The block also drives the active-low request-to-send pin. Software asserts and negates it with set and clear commands. When automatic flow control is enabled, the pin output is enabled and software has asserted the pin, a start bit that arrives while the queue is full negates the pin. The pin is asserted again once a slot frees up.

The three reported status bits work in one of two ways. In per-character mode they show the status of the top character only. In accumulate mode they show the OR of every character that has reached the top since the last error-clear command.

The request-to-send control is a three-state machine:

| State | Meaning |
|---|---|
| RTS_NEGATED | Negated by command. The pin is high. |
| RTS_ASSERTED | Asserted by command. The pin is low. |
| RTS_AUTO_HOLD | Negated by the flow control. The pin is high. |

Its transitions:

- **NEGATED→ASSERTED** on a set command without a clear command.
- **ASSERTED→NEGATED** on a clear command.
- **ASSERTED→AUTO_HOLD** when flow control and the output enable are both high and a start bit is seen while the queue is full.
- **AUTO_HOLD→NEGATED** on a clear command.
- **AUTO_HOLD→ASSERTED** when the queue is no longer full, or when flow control or the output enable drops.

Top module: `rx_fifo_flow`

## Requirements
- R1: After reset, and until the first command, the outputs are: empty=1, full=0, ready=0, overrun=0, rts_n=1, and all three reported status bits 0.
- R2: Characters leave in the order they arrived. The queue holds DEPTH (8) characters. `full` rises on the edge that stores the eighth character. `ready` is the inverse of `empty`.
- R3: A push while full, with no pop in the same cycle, is dropped and the queue contents are unchanged. The drop sets the sticky `overrun` flag. The flag stays set until an `err_clr` command, which clears it on the next edge.
- R4: A push and a pop in the same cycle on a full queue are both accepted. The queue stays full and the next character moves to the top.
- R5: A pop on an empty queue has no effect. The queue stays empty.
- R6: With `blk_mode`=0, the reported status {brk,fe,pe} is the status of the top character. When the queue is empty the status reads 0 and `top_data` reads 0.
- R7: With `blk_mode`=1, each reported status bit is the OR of that bit over every character that reached the top since the last `err_clr`. A character's bits are ORed in on the edge where it becomes the top entry.
- R8: `err_clr` zeroes the accumulated status on the next edge. If a character becomes the top entry on that same edge, the accumulated status takes that character's bits.
- R9: `rts_set` drives rts_n low on the next edge. `rts_clr` drives rts_n high on the next edge. When both arrive in the same cycle, the clear wins.
- R10: The pin is auto-negated when all of these hold: rts_n is asserted, `flow_en`=1, `rts_oe`=1, and `start_det` arrives while `full`=1. rts_n then goes high on the next edge.
- R11: After an auto-negation, rts_n returns low on the edge after the one where `full` falls.
- R12: With `flow_en`=0 or `rts_oe`=0, a start bit on a full queue leaves rts_n unchanged. If either input drops while the pin is auto-negated, rts_n returns to the commanded asserted level on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_det | input | 1 | One-cycle pulse: start bit detected |
| push | input | 1 | Character complete: store the byte and its status |
| push_data | input | 8 | Received data byte |
| push_brk | input | 1 | Received break status |
| push_fe | input | 1 | Framing error status |
| push_pe | input | 1 | Parity error status |
| pop | input | 1 | Host removes the top character |
| flow_en | input | 1 | Enables automatic request-to-send negation |
| blk_mode | input | 1 | 0 = per-character status, 1 = accumulated status |
| rts_oe | input | 1 | Request-to-send pin is configured as an output |
| rts_set | input | 1 | Command: assert request-to-send |
| rts_clr | input | 1 | Command: negate request-to-send |
| err_clr | input | 1 | Command: clear the accumulated status and overrun |
| top_data | output | 8 | Data byte of the top character (0 when empty) |
| rpt_brk | output | 1 | Reported break status |
| rpt_fe | output | 1 | Reported framing error status |
| rpt_pe | output | 1 | Reported parity error status |
| full | output | 1 | Queue holds DEPTH characters |
| empty | output | 1 | Queue holds no characters |
| ready | output | 1 | At least one character is available |
| overrun | output | 1 | Sticky flag: a character was dropped |
| rts_n | output | 1 | Active-low request-to-send pin level |

## Verification
These results appear one rising edge after the stimulus that causes them:

- the flags, the top byte and both status modes (the queue and accumulator are registers, read through logic only);
- the commanded and automatic pin changes (the pin comes from the state register).

Release after auto-negation takes two edges from the freeing pop: one for `full` to fall, and one for the state machine to see it. The bench applies stimulus, waits for one rising edge, and samples 2 ns later. It checks the intermediate cycle of the release explicitly, then spends an idle cycle before expecting the pin low.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
    localparam int unsigned RXF_DW = 8;
    localparam int unsigned RXF_SW = 3;

    typedef struct packed {
        logic [RXF_DW-1:0] data;
        logic              brk;
        logic              fe;
        logic              pe;
    } rxf_entry_t;

    typedef enum logic [1:0] {
        RTS_NEGATED   = 2'd0,
        RTS_ASSERTED  = 2'd1,
        RTS_AUTO_HOLD = 2'd2
    } rts_state_e;
endpackage

// File: rtl/rxf_store.sv
module rxf_store
    import rxf_pkg::*;
#(
    parameter int unsigned DEPTH = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    push,
    input  rxf_entry_t              push_ent,
    input  logic                    pop,
    output rxf_entry_t              top_ent,
    output logic                    empty,
    output logic                    full,
    output logic                    arrive,
    output logic [RXF_SW-1:0]       arrive_st,
    output logic                    drop
);
    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = $clog2(DEPTH + 1);

    rxf_entry_t       mem [DEPTH];
    logic [AW-1:0]    wr_ptr;
    logic [AW-1:0]    rd_ptr;
    logic [CW-1:0]    count;
    logic             pop_ok;
    logic             push_ok;
    rxf_entry_t       next_top;

    function automatic logic [AW-1:0] step_ptr(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign pop_ok  = pop && !empty;
    assign push_ok = push && (!full || pop_ok);
    assign drop    = push && !push_ok;

    always_comb begin
        arrive   = 1'b0;
        next_top = '0;
        if (push_ok && (empty || (pop_ok && count == CW'(1)))) begin
            arrive   = 1'b1;
            next_top = push_ent;
        end else if (pop_ok && count > CW'(1)) begin
            arrive   = 1'b1;
            next_top = mem[step_ptr(rd_ptr)];
        end
    end

    assign arrive_st = {next_top.brk, next_top.fe, next_top.pe};
    assign top_ent   = empty ? '0 : mem[rd_ptr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(DEPTH); i++) begin
                mem[i] <= '0;
            end
        end else if (push_ok) begin
            mem[wr_ptr] <= push_ent;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) begin
                wr_ptr <= step_ptr(wr_ptr);
            end
            if (pop_ok) begin
                rd_ptr <= step_ptr(rd_ptr);
            end
            unique case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH)); // R2
    AST_DROP_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        push && !pop && full |=> full && $stable(wr_ptr) && $stable(rd_ptr)); // R3
    AST_SWAP_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        push && pop && full |=> full); // R4
    AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
        pop && !push && empty |=> empty); // R5
endmodule

// File: rtl/rxf_status.sv
module rxf_status
    import rxf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              blk_mode,
    input  logic              err_clr,
    input  logic [RXF_SW-1:0] top_st,
    input  logic              arrive,
    input  logic [RXF_SW-1:0] arrive_st,
    input  logic              drop,
    output logic [RXF_SW-1:0] rpt_st,
    output logic              overrun
);
    logic [RXF_SW-1:0] acc;

    for (genvar b = 0; b < RXF_SW; b++) begin : g_acc
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                acc[b] <= 1'b0;
            end else if (err_clr) begin
                acc[b] <= arrive && arrive_st[b];
            end else if (arrive) begin
                acc[b] <= acc[b] | arrive_st[b];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            overrun <= 1'b0;
        end else begin
            overrun <= drop | (overrun & ~err_clr);
        end
    end

    assign rpt_st = blk_mode ? acc : top_st;

    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        overrun && !err_clr |=> overrun); // R3
    AST_ACC_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        arrive && !err_clr |=> (acc & $past(arrive_st)) == $past(arrive_st)); // R7
    AST_ERRCLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        err_clr && !arrive |=> acc == '0); // R8
endmodule

// File: rtl/rxf_rts_fsm.sv
module rxf_rts_fsm
    import rxf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rts_set,
    input  logic rts_clr,
    input  logic flow_en,
    input  logic rts_oe,
    input  logic start_det,
    input  logic full,
    output logic rts_n
);
    rts_state_e state;
    rts_state_e state_nx;
    logic       auto_ok;

    assign auto_ok = flow_en && rts_oe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= RTS_NEGATED;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            RTS_NEGATED: begin
                if (rts_set && !rts_clr) begin
                    state_nx = RTS_ASSERTED;
                end
            end
            RTS_ASSERTED: begin
                if (rts_clr) begin
                    state_nx = RTS_NEGATED;
                end else if (auto_ok && start_det && full) begin
                    state_nx = RTS_AUTO_HOLD;
                end
            end
            RTS_AUTO_HOLD: begin
                if (rts_clr) begin
                    state_nx = RTS_NEGATED;
                end else if (!auto_ok || !full) begin
                    state_nx = RTS_ASSERTED;
                end
            end
            default: state_nx = RTS_NEGATED;
        endcase
    end

    always_comb begin
        unique case (state)
            RTS_ASSERTED: rts_n = 1'b0;
            default:      rts_n = 1'b1;
        endcase
    end

    AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        rts_clr |=> rts_n); // R9
    AST_AUTO_NEGATE: assert property (@(posedge clk) disable iff (!rst_n)
        !rts_n && auto_ok && start_det && full && !rts_clr |=> rts_n); // R10
    AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        state == RTS_AUTO_HOLD && !full && !rts_clr |=> !rts_n); // R11
    AST_FOLLOW_MANUAL: assert property (@(posedge clk) disable iff (!rst_n)
        state == RTS_AUTO_HOLD && !auto_ok && !rts_clr |=> !rts_n); // R12
endmodule

// File: rtl/rx_fifo_flow.sv
module rx_fifo_flow
    import rxf_pkg::*;
#(
    parameter int unsigned DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_det,
    input  logic              push,
    input  logic [RXF_DW-1:0] push_data,
    input  logic              push_brk,
    input  logic              push_fe,
    input  logic              push_pe,
    input  logic              pop,
    input  logic              flow_en,
    input  logic              blk_mode,
    input  logic              rts_oe,
    input  logic              rts_set,
    input  logic              rts_clr,
    input  logic              err_clr,
    output logic [RXF_DW-1:0] top_data,
    output logic              rpt_brk,
    output logic              rpt_fe,
    output logic              rpt_pe,
    output logic              full,
    output logic              empty,
    output logic              ready,
    output logic              overrun,
    output logic              rts_n
);
    rxf_entry_t        push_ent;
    rxf_entry_t        top_ent;
    logic              arrive;
    logic [RXF_SW-1:0] arrive_st;
    logic              drop;
    logic [RXF_SW-1:0] rpt_st;

    assign push_ent = '{data: push_data, brk: push_brk, fe: push_fe, pe: push_pe};

    rxf_store #(.DEPTH(DEPTH)) store_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_ent  (push_ent),
        .pop       (pop),
        .top_ent   (top_ent),
        .empty     (empty),
        .full      (full),
        .arrive    (arrive),
        .arrive_st (arrive_st),
        .drop      (drop)
    );

    rxf_status status_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .blk_mode  (blk_mode),
        .err_clr   (err_clr),
        .top_st    ({top_ent.brk, top_ent.fe, top_ent.pe}),
        .arrive    (arrive),
        .arrive_st (arrive_st),
        .drop      (drop),
        .rpt_st    (rpt_st),
        .overrun   (overrun)
    );

    rxf_rts_fsm rts_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .rts_set   (rts_set),
        .rts_clr   (rts_clr),
        .flow_en   (flow_en),
        .rts_oe    (rts_oe),
        .start_det (start_det),
        .full      (full),
        .rts_n     (rts_n)
    );

    assign top_data = top_ent.data;
    assign {rpt_brk, rpt_fe, rpt_pe} = rpt_st;
    assign ready = !empty;

    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty)); // R2
    AST_EMPTY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        empty && !blk_mode |-> top_data == '0 && rpt_st == '0); // R6
endmodule

// File: tb/rx_fifo_flow_tb_top.sv
module rx_fifo_flow_tb_top;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       start_det, push, pop, flow_en, blk_mode, rts_oe;
    logic       rts_set, rts_clr, err_clr;
    logic [7:0] push_data;
    logic [2:0] push_st;
    logic [7:0] top_data;
    logic       rpt_brk, rpt_fe, rpt_pe, full, empty, ready, overrun, rts_n;
    int         checks = 0;
    int         errors = 0;
    bit         done = 1'b0;

    always #5 clk = ~clk;

    rx_fifo_flow dut_i (
        .clk(clk), .rst_n(rst_n), .start_det(start_det), .push(push),
        .push_data(push_data), .push_brk(push_st[2]), .push_fe(push_st[1]),
        .push_pe(push_st[0]), .pop(pop), .flow_en(flow_en), .blk_mode(blk_mode),
        .rts_oe(rts_oe), .rts_set(rts_set), .rts_clr(rts_clr), .err_clr(err_clr),
        .top_data(top_data), .rpt_brk(rpt_brk), .rpt_fe(rpt_fe), .rpt_pe(rpt_pe),
        .full(full), .empty(empty), .ready(ready), .overrun(overrun), .rts_n(rts_n)
    );

    // {push, data, st, pop,start,set,clr,errclr,blk,flow,oe,
    //  exp empty,full, exp data, exp rpt, exp rts_n,overrun}
    localparam logic [34:0] VEC [13] = '{
        {1'b0, 8'h00, 3'b000, 8'b00100011, 2'b10, 8'h00, 3'b000, 2'b00},
        {1'b1, 8'h11, 3'b001, 8'b00000011, 2'b00, 8'h11, 3'b001, 2'b00},
        {1'b1, 8'h22, 3'b010, 8'b00000011, 2'b00, 8'h11, 3'b001, 2'b00},
        {1'b0, 8'h00, 3'b000, 8'b10000011, 2'b00, 8'h22, 3'b010, 2'b00},
        {1'b1, 8'h33, 3'b100, 8'b10000011, 2'b00, 8'h33, 3'b100, 2'b00},
        {1'b0, 8'h00, 3'b000, 8'b10000011, 2'b10, 8'h00, 3'b000, 2'b00},
        {1'b0, 8'h00, 3'b000, 8'b10000011, 2'b10, 8'h00, 3'b000, 2'b00},
        {1'b0, 8'h00, 3'b000, 8'b00001111, 2'b10, 8'h00, 3'b000, 2'b00},
        {1'b1, 8'h44, 3'b001, 8'b00000111, 2'b00, 8'h44, 3'b001, 2'b00},
        {1'b1, 8'h55, 3'b010, 8'b00000111, 2'b00, 8'h44, 3'b001, 2'b00},
        {1'b0, 8'h00, 3'b000, 8'b10000111, 2'b00, 8'h55, 3'b011, 2'b00},
        {1'b0, 8'h00, 3'b000, 8'b10000111, 2'b10, 8'h00, 3'b011, 2'b00},
        {1'b0, 8'h00, 3'b000, 8'b00001111, 2'b10, 8'h00, 3'b000, 2'b00}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic quiet();
        push = 0; pop = 0; start_det = 0; rts_set = 0; rts_clr = 0; err_clr = 0;
        push_data = '0; push_st = '0;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        quiet();
        flow_en = 1; rts_oe = 1; blk_mode = 0;
        rst_n = 0;
        repeat (3) @(posedge clk);
        #2 rst_n = 1;
        #1;
        // R1 reset state
        chk("R1 empty", 32'(empty), 1);
        chk("R1 full", 32'(full), 0);
        chk("R1 ready", 32'(ready), 0);
        chk("R1 overrun", 32'(overrun), 0);
        chk("R1 rts_n", 32'(rts_n), 1);
        chk("R1 status", 32'({rpt_brk, rpt_fe, rpt_pe}), 0);

        // vector table: R2 R5 R6 R7 R8 R9
        for (int v = 0; v < 13; v++) begin
            logic [34:0] w;
            w = VEC[v];
            push = w[34]; push_data = w[33:26]; push_st = w[25:23];
            pop = w[22]; start_det = w[21]; rts_set = w[20]; rts_clr = w[19];
            err_clr = w[18]; blk_mode = w[17]; flow_en = w[16]; rts_oe = w[15];
            tick();
            quiet();
            chk($sformatf("R2/R5 vec%0d flags", v), 32'({empty, full}), 32'(w[14:13]));
            chk($sformatf("R2/R6 vec%0d data", v), 32'(top_data), 32'(w[12:5]));
            chk($sformatf("R6/R7/R8 vec%0d status", v), 32'({rpt_brk, rpt_fe, rpt_pe}), 32'(w[4:2]));
            chk($sformatf("R9 vec%0d rts_ovr", v), 32'({rts_n, overrun}), 32'(w[1:0]));
        end
        blk_mode = 0;

        // R2 fill to depth
        for (int i = 0; i < 8; i++) begin
            push = 1; push_data = 8'hA0 + 8'(i);
            tick();
            quiet();
            chk($sformatf("R2 full after %0d pushes", i + 1), 32'(full), (i == 7) ? 1 : 0);
        end
        chk("R2 oldest on top", 32'(top_data), 32'hA0);
        chk("R2 ready", 32'(ready), 1);

        // R10 auto negate
        start_det = 1; tick(); quiet();
        chk("R10 rts_n negated", 32'(rts_n), 1);

        // R3 drop on full
        push = 1; push_data = 8'hBB; tick(); quiet();
        chk("R3 still full", 32'(full), 1);
        chk("R3 top unchanged", 32'(top_data), 32'hA0);
        chk("R3 overrun set", 32'(overrun), 1);

        // R4 push+pop on full
        push = 1; push_data = 8'hEE; pop = 1; tick(); quiet();
        chk("R4 stays full", 32'(full), 1);
        chk("R4 next on top", 32'(top_data), 32'hA1);

        // R11 release timing
        pop = 1; tick(); quiet();
        chk("R11 full fell", 32'(full), 0);
        chk("R11 rts_n held this cycle", 32'(rts_n), 1);
        tick();
        chk("R11 rts_n released", 32'(rts_n), 0);

        // R2 order of the rest, with EE after A7
        for (int k = 0; k < 7; k++) begin
            pop = 1; tick(); quiet();
            if (k <= 4)      chk("R2 drain order", 32'(top_data), 32'hA3 + k);
            else if (k == 5) chk("R2 drain order", 32'(top_data), 32'hEE);
            else             chk("R2 drained empty", 32'(empty), 1);
        end
        chk("R3 overrun sticky", 32'(overrun), 1);
        err_clr = 1; tick(); quiet();
        chk("R3 overrun cleared", 32'(overrun), 0);

        // R12 enables gate the automatic negation
        for (int i = 0; i < 8; i++) begin
            push = 1; push_data = 8'hC0 + 8'(i); tick(); quiet();
        end
        flow_en = 0; start_det = 1; tick(); quiet();
        chk("R12 flow_en low ignores start", 32'(rts_n), 0);
        flow_en = 1; rts_oe = 0; start_det = 1; tick(); quiet();
        chk("R12 rts_oe low ignores start", 32'(rts_n), 0);
        rts_oe = 1; start_det = 1; tick(); quiet();
        chk("R10 negated when enabled", 32'(rts_n), 1);
        rts_oe = 0; tick();
        chk("R12 follows manual when disabled", 32'(rts_n), 0);
        rts_oe = 1;

        // R9 manual commands
        rts_clr = 1; tick(); quiet();
        chk("R9 clear negates", 32'(rts_n), 1);
        rts_set = 1; tick(); quiet();
        chk("R9 set asserts", 32'(rts_n), 0);
        rts_set = 1; rts_clr = 1; tick(); quiet();
        chk("R9 clear wins", 32'(rts_n), 1);

        // R1 reset mid-run
        rst_n = 0; #3;
        chk("R1 reset empties", 32'({empty, full, ready}), 32'b100);
        chk("R1 reset rts_n", 32'(rts_n), 1);
        #10 rst_n = 1;
        tick();
        chk("R1 stays after reset", 32'({empty, overrun, rts_n}), 32'b101);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule